// File: doc/BRIEF.md
# Multi-Lane Byte Stream Merger

This block sits after per-lane deserializers in a serial camera receiver. The transmitter spreads one byte stream over one, two or four lanes. Byte k of the stream goes to lane k mod N. Each lane reaches this block as its own byte flow and arrives with its own delay. The block holds every lane in a small skew buffer, waits until all active lanes have started a burst, and then reads the lanes in rotation. The result is the original stream, one byte per clock, with an end-of-packet flag on the last byte.

Each lane carries three kinds of token. A start marker opens a burst. Data bytes follow. An end marker closes the lane's share of the burst. Lanes after the last byte of an uneven burst carry one byte fewer than the leading lanes. Their end markers are what let the block flag the final byte without waiting for data that will never come. If a skew buffer overflows, a sticky error is raised. The rest of that burst is thrown away, and the next burst starts clean on fresh start markers.

Top module: `lane_merge`

## Requirements
- R1: `cfg_lanes` selects the active lane count: 0 or 1 gives one lane, 2 or 3 gives two lanes, and 4 to 7 gives four lanes. Lane 0 is always active.
- R2: Output bytes follow strict rotation lane 0, lane 1, ..., lane N-1, then lane 0 again. The first output byte is lane 0's first data byte after its start marker. At most one byte is output per clock.
- R3: No byte is output until every active lane has presented its start marker. With 16-entry skew buffers and lanes running at 1/N of the byte rate, start markers up to 8 clocks apart still merge correctly.
- R4: `out_eop` is high together with `out_valid` on the last byte of a burst. This holds for every burst length, including a length that is not a multiple of N and a length of one byte.
- R5: Inputs of inactive lanes have no effect on the output.
- R6: Data bytes on a lane before its start marker are discarded.
- R7: A push into a full skew buffer sets `sync_err`, which stays high until reset. No byte of that burst is output afterwards, and a later burst opened by fresh start markers merges normally.
- R8: After reset, `out_valid`, `out_eop` and `sync_err` are low.
- R9: Token priority per lane per clock is start marker (`lane_sob`), then end marker (`lane_eob`), then data (`lane_valid`). On a marker clock the data bus is ignored.
- R10: `out_eop` is never high without `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lanes | input | 3 | Static lane count selection (R1) |
| lane_data | input | 32 | Lane bytes; lane i uses bits [8i+7:8i] |
| lane_valid | input | 4 | Per-lane data byte present |
| lane_sob | input | 4 | Per-lane start-of-burst marker |
| lane_eob | input | 4 | Per-lane end-of-burst marker |
| out_data | output | 8 | Merged byte |
| out_valid | output | 1 | Merged byte present |
| out_eop | output | 1 | Last byte of the burst |
| sync_err | output | 1 | Sticky skew-buffer overflow flag |

## Verification
Bursts are run in each lane mode with lengths that are multiples of the lane count, lengths that are not, and a length of one byte. These tell a correct rotation and end flag apart from an end flag that is early or late, or missing on lanes that carry one byte fewer. Skewed start markers, with lane 0 both earliest and latest, separate a merger that really waits for every lane from one that starts on lane 0 alone. Noise on unused lanes, junk bytes before the start marker and garbage on the data bus during marker clocks each expose a lane that is sampled when it should not be. A held-back lane forces an overflow, and the bursts that follow show both the discard and the recovery.

// File: rtl/lane_merge.sv
module lane_merge #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_lanes,
  input  logic [4*DW-1:0]   lane_data,
  input  logic [3:0]        lane_valid,
  input  logic [3:0]        lane_sob,
  input  logic [3:0]        lane_eob,
  output logic [DW-1:0]     out_data,
  output logic              out_valid,
  output logic              out_eop,
  output logic              sync_err
);
  localparam int LANES = 4;
  localparam int PW = $clog2(DEPTH);
  localparam int TW = 2;
  localparam int EW = DW + TW;
  localparam logic [TW-1:0] TAG_SOB = 2'd1, TAG_DAT = 2'd2, TAG_EOB = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} st_t;

  logic [2:0] nlanes;
  logic [1:0] lmask;
  logic [LANES-1:0] act;

  always_comb begin
    case (cfg_lanes)
      3'd0, 3'd1: nlanes = 3'd1;
      3'd2, 3'd3: nlanes = 3'd2;
      default:    nlanes = 3'd4;
    endcase
  end
  assign lmask = 2'(nlanes - 3'd1);
  assign act   = {nlanes[2], nlanes[2], nlanes[2] | nlanes[1], 1'b1};

  logic ovf;
  logic [LANES-1:0] ne, deep, full, push, pop;
  logic [LANES-1:0][EW-1:0] head, nxt;
  logic [LANES-1:0][TW-1:0] htag;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [EW-1:0] ram [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [PW:0]   cnt;
    logic [TW-1:0] tag;

    assign tag     = lane_sob[i] ? TAG_SOB : (lane_eob[i] ? TAG_EOB : TAG_DAT);
    assign push[i] = act[i] & (lane_sob[i] | lane_eob[i] | lane_valid[i]);
    assign head[i] = ram[rp];
    assign nxt[i]  = ram[rp + PW'(1)];
    assign htag[i] = head[i][EW-1 -: TW];
    assign ne[i]   = cnt != '0;
    assign deep[i] = cnt >= (PW+1)'(2);
    assign full[i] = cnt == (PW+1)'(DEPTH);

    always_ff @(posedge clk)
      if (push[i] && !ovf) ram[wp] <= {tag, lane_data[i*DW +: DW]};

    always_ff @(posedge clk) begin
      if (!rst_n || ovf || !act[i]) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (push[i]) wp <= wp + PW'(1);
        if (pop[i])  rp <= rp + PW'(1);
        cnt <= cnt + (PW+1)'(push[i]) - (PW+1)'(pop[i]);
      end
    end

    p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pop[i] |-> ne[i]);
  end

  assign ovf = |(push & full & ~pop);

  st_t st, st_n;
  logic [1:0] ptr, ptr_n, q;
  logic [LANES-1:0] closed, close_now;
  logic emit, emit_eop, all_sob, look_ok;
  logic [TW-1:0] look_tag;

  always_comb begin
    pop       = '0;
    close_now = '0;
    emit      = 1'b0;
    emit_eop  = 1'b0;
    st_n      = st;
    ptr_n     = ptr;
    q         = (ptr + 2'd1) & lmask;
    look_ok   = (nlanes == 3'd1) ? deep[ptr] : ne[q];
    look_tag  = (nlanes == 3'd1) ? nxt[ptr][EW-1 -: TW] : htag[q];
    all_sob   = 1'b1;
    for (int i = 0; i < LANES; i++)
      if (act[i] && !(ne[i] && htag[i] == TAG_SOB)) all_sob = 1'b0;
    unique case (st)
      S_IDLE: begin
        if (all_sob) begin
          pop   = act;
          st_n  = S_RUN;
          ptr_n = 2'd0;
        end else begin
          for (int i = 0; i < LANES; i++)
            if (act[i] && ne[i] && htag[i] != TAG_SOB) pop[i] = 1'b1;
        end
      end
      S_RUN: begin
        if (ne[ptr]) begin
          case (htag[ptr])
            TAG_EOB: st_n = S_DRAIN;
            TAG_SOB: pop[ptr] = 1'b1;
            default: if (look_ok) begin
              pop[ptr] = 1'b1;
              emit     = 1'b1;
              emit_eop = look_tag == TAG_EOB;
              ptr_n    = q;
              if (look_tag == TAG_EOB) st_n = S_DRAIN;
            end
          endcase
        end
      end
      S_DRAIN: begin
        for (int i = 0; i < LANES; i++)
          if (act[i] && !closed[i] && ne[i]) begin
            pop[i] = 1'b1;
            if (htag[i] == TAG_EOB) close_now[i] = 1'b1;
          end
        if (&(closed | close_now | ~act)) st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ptr       <= '0;
      closed    <= '0;
      out_valid <= 1'b0;
      out_eop   <= 1'b0;
      out_data  <= '0;
      sync_err  <= 1'b0;
    end else if (ovf) begin
      st        <= S_IDLE;
      ptr       <= '0;
      closed    <= '0;
      out_valid <= 1'b0;
      out_eop   <= 1'b0;
      sync_err  <= 1'b1;
    end else begin
      st        <= st_n;
      ptr       <= ptr_n;
      out_valid <= emit;
      out_eop   <= emit_eop;
      if (emit) out_data <= head[ptr][DW-1:0];
      closed    <= (st == S_DRAIN && st_n == S_DRAIN) ? (closed | close_now) : '0;
    end
  end

  p_eop_with_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |-> out_valid);
  p_eop_then_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |-> st == S_DRAIN);
  p_quiet_outside_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_RUN) |=> !out_valid);
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> sync_err);
endmodule

// File: tb/lane_merge_test.sv
module lane_merge_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_lanes = 3'd1;
  logic [31:0] lane_data = '0;
  logic [3:0]  lane_valid = '0, lane_sob = '0, lane_eob = '0;
  logic [7:0]  out_data;
  logic        out_valid, out_eop, sync_err;

  int vectors = 0;
  int fails = 0;
  logic [8:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_merge uut (
    .clk(clk), .rst_n(rst_n), .cfg_lanes(cfg_lanes), .lane_data(lane_data),
    .lane_valid(lane_valid), .lane_sob(lane_sob), .lane_eob(lane_eob),
    .out_data(out_data), .out_valid(out_valid), .out_eop(out_eop), .sync_err(sync_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference model: every output byte is compared against the queue (R2, R4, R10)
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        vectors++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R2: got byte %h eop %b expected no output", out_data, out_eop);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          if ({out_eop, out_data} != e) begin
            fails++;
            $display("FAIL R2/R4: got eop %b byte %h expected eop %b byte %h",
                     out_eop, out_data, e[8], e[7:0]);
          end
        end
      end else if (out_eop) begin
        vectors++;
        fails++;
        $display("FAIL R10: got eop 1 without valid expected 0");
      end
    end
  end

  task automatic idle_inputs();
    lane_valid = '0; lane_sob = '0; lane_eob = '0; lane_data = '0;
  endtask

  // One burst of len bytes over n lanes, lane i starting sk_i clocks late.
  // Marker clocks carry valid=1 and junk data (R9); junk precedes start (R6);
  // inactive lanes can carry noise (R5).
  task automatic run_burst(input int cfg, input int n, input int len,
                           input int s0, input int s1, input int s2, input int s3,
                           input int base, input int junk, input bit noise,
                           input string tag);
    int sk[4];
    int nb[4];
    int last;
    sk = '{s0, s1, s2, s3};
    for (int i = 0; i < 4; i++) nb[i] = (i < n && len > i) ? (len - i + n - 1) / n : 0;
    for (int k = 0; k < len; k++) exp_q.push_back({(k == len - 1), 8'(base + k)});
    cfg_lanes = 3'(cfg);
    last = junk + 12 + n * (nb[0] + 1);
    for (int c = 0; c < last; c++) begin
      @(posedge clk); #1;
      lane_valid = '0; lane_sob = '0; lane_eob = '0; lane_data = {4{8'hEE}};
      for (int i = 0; i < 4; i++) begin
        int t;
        if (i >= n) begin
          if (noise) begin
            lane_valid[i] = c[0];
            lane_sob[i]   = (c % 5 == 1);
            lane_eob[i]   = (c % 7 == 3);
            lane_data[i*8 +: 8] = 8'(c * 13 + i);
          end
        end else if (c < junk) begin
          lane_valid[i] = 1'b1;
          lane_data[i*8 +: 8] = 8'hA5;
        end else begin
          t = c - junk - sk[i];
          if (t == 0) begin
            lane_sob[i] = 1'b1; lane_valid[i] = 1'b1;
          end else if (t >= 1 && (t - 1) % n == 0 && (t - 1) / n < nb[i]) begin
            lane_valid[i] = 1'b1;
            lane_data[i*8 +: 8] = 8'(base + i + ((t - 1) / n) * n);
          end else if (t == 1 + nb[i] * n) begin
            lane_eob[i] = 1'b1; lane_valid[i] = 1'b1;
          end
        end
      end
    end
    @(posedge clk); #1;
    idle_inputs();
    repeat (40) @(posedge clk);
    #1;
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 valid after reset", out_valid, 0);
    chk(out_eop == 1'b0, "R8 eop after reset", out_eop, 0);
    chk(sync_err == 1'b0, "R8 error after reset", sync_err, 0);

    run_burst(1, 1, 5, 0, 0, 0, 0, 8'h10, 0, 1'b1, "R2 R5 one lane with noise");
    run_burst(0, 1, 3, 0, 0, 0, 0, 8'h20, 0, 1'b0, "R1 cfg 0 as one lane");
    run_burst(2, 2, 7, 0, 2, 0, 0, 8'h30, 0, 1'b1, "R4 R5 two lanes odd length");
    run_burst(3, 2, 6, 1, 0, 0, 0, 8'h40, 0, 1'b1, "R1 cfg 3 as two lanes");
    run_burst(4, 4, 10, 0, 0, 0, 0, 8'h50, 0, 1'b0, "R4 four lanes uneven end");
    run_burst(4, 4, 16, 0, 3, 6, 8, 8'h60, 0, 1'b0, "R3 skew lane 0 first");
    run_burst(4, 4, 13, 8, 0, 2, 5, 8'h80, 0, 1'b0, "R3 skew lane 0 last");
    run_burst(4, 4, 1, 0, 1, 2, 3, 8'h90, 0, 1'b0, "R4 single byte burst");
    run_burst(6, 4, 8, 0, 0, 0, 0, 8'hA0, 0, 1'b0, "R1 cfg 6 as four lanes");
    run_burst(2, 2, 9, 0, 1, 0, 0, 8'hB0, 4, 1'b0, "R6 R9 junk before start");
    chk(sync_err == 1'b0, "R7 no false error", sync_err, 0);

    // R7: lane 3 never starts, lanes 0-2 run full rate until a buffer overflows
    cfg_lanes = 3'd4;
    @(posedge clk); #1;
    lane_sob = 4'b0111;
    for (int c = 0; c < 24; c++) begin
      @(posedge clk); #1;
      lane_sob = '0;
      lane_valid = 4'b0111;
      lane_data = {8'h00, 8'(c + 2), 8'(c + 1), 8'(c)};
    end
    @(posedge clk); #1;
    lane_valid = '0; lane_eob = 4'b0111;
    @(posedge clk); #1;
    idle_inputs();
    repeat (20) @(posedge clk);
    #1;
    chk(sync_err == 1'b1, "R7 overflow flagged", sync_err, 1);
    chk(exp_q.size() == 0, "R7 discarded burst", exp_q.size(), 0);

    run_burst(4, 4, 12, 0, 2, 1, 0, 8'hC0, 0, 1'b0, "R7 recovery burst");
    chk(sync_err == 1'b1, "R7 error sticky", sync_err, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule